// File: doc/BRIEF.md
# Four-Mode Serial Port Controller

A full-duplex serial port with four operating modes selected by a 2-bit mode input. Mode 0 is a synchronous 8-bit shifter: the port drives its own shift clock on the transmit pin and moves data, least significant bit first, on the bidirectional receive pin. Mode 1 is an asynchronous 8-bit frame. Modes 2 and 3 are asynchronous 9-bit frames. Mode 2 runs from a fixed divide of the block clock, which stands for the oscillator. Modes 1 and 3 run from an overflow pulse supplied by an external timer.

The asynchronous receiver samples each bit 16 times and decides its value by a majority vote of three samples around mid-bit. A start bit that does not hold low at mid-bit is rejected. Received frames go through an address filter that serves multiprocessor networks and can keep the receive-done flag from being raised. The block keeps sticky transmit-done, receive-done and error flags, and software clears each of them through its own clear strobe. A received byte that arrives while receive-done is still set is counted as an overrun: the error flag is raised and the held byte is kept. A stop bit sampled low is a framing fault and also raises the error flag.

Top module: `serial_port_ctl`

## Requirements
- R1: Out of reset, tx_done, rx_done and rx_error are 0, rxd_oe is 0 and txd_out idles at 1.
- R2: In mode 0 (mode=0), a tx_load pulse sends tx_data least significant bit first on rxd_out with rxd_oe=1. Each bit lasts 12 clocks, and txd_out carries the shift clock, low for the first 6 clocks of each bit and high for the last 6. tx_done is set 96 clocks after the load edge.
- R3: In mode 0, while rx_enable=1 and rx_done=0, the port starts its own 8-bit reception. Each bit is sampled at the rising edge of the shift clock, least significant bit first. rx_done is set 96 clocks after the start edge, with the byte on rx_data.
- R4: In modes 1 to 3 a tx_load pulse sends a frame on txd_out: a 0 start bit, 8 data bits least significant bit first, then in modes 2 and 3 the tx_bit9 value, then a 1 stop bit. Each bit lasts 16 sample ticks. tx_done is set at the end of the stop bit.
- R5: Sample ticks come from timer_tick in modes 1 and 3, on every pulse when clk_double=1 and on every second pulse when it is 0. In mode 2 they come from the clock divided by 2 when clk_double=1 and by 4 when it is 0, so one bit lasts 32 or 64 clocks.
- R6: The receiver takes a majority of samples 7, 8 and 9 of each bit. A low pulse that is back high by mid-bit is dropped as a false start, and the next valid frame is received correctly.
- R7: In mode 1 with addr_filter=0, every frame is accepted and its stop bit value is stored on rx_bit9.
- R8: In mode 1 with addr_filter=1, a frame is accepted only if its stop bit is 1. A rejected frame leaves rx_done and rx_data unchanged.
- R9: In modes 2 and 3 the received ninth bit is stored on rx_bit9. With addr_filter=1, a frame whose ninth bit is 0 leaves rx_done at 0 and rx_data unchanged.
- R10: With rx_enable=0 no frame is received: rx_done stays 0 and rx_data keeps its value.
- R11: A frame that passes the filter while rx_done is still 1 sets rx_error and leaves rx_data unchanged.
- R12: A stop bit received as 0 sets rx_error. Each flag stays set until its clear strobe (clr_tx_done, clr_rx_done, clr_err) is pulsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, taken as the oscillator |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | 0 synchronous, 1 8-bit frame, 2 9-bit fixed rate, 3 9-bit timer rate |
| rx_enable | input | 1 | Receiver enable |
| addr_filter | input | 1 | Multiprocessor address filter enable |
| clk_double | input | 1 | Rate doubling select |
| tx_bit9 | input | 1 | Ninth bit to send in modes 2 and 3 |
| timer_tick | input | 1 | Timer overflow pulse used as baud source |
| tx_load | input | 1 | Start transmission of tx_data |
| tx_data | input | 8 | Byte to send |
| clr_tx_done | input | 1 | Clears tx_done |
| clr_rx_done | input | 1 | Clears rx_done |
| clr_err | input | 1 | Clears rx_error |
| rxd_in | input | 1 | Receive pin input |
| rxd_out | output | 1 | Receive pin output data (mode 0 transmit) |
| rxd_oe | output | 1 | Receive pin output enable |
| txd_out | output | 1 | Transmit pin: frame data or shift clock |
| tx_done | output | 1 | Transmit-done flag |
| rx_done | output | 1 | Receive-done flag |
| rx_error | output | 1 | Sticky overrun or framing error flag |
| rx_data | output | 8 | Received byte buffer |
| rx_bit9 | output | 1 | Received ninth bit or stop bit |

## Verification
Transmit results have fixed latencies counted from the load edge. In mode 0 a bit changes every 12 clocks and tx_done is set 96 clocks after the load edge. In the frame modes with one tick per clock, bit k is sampled at clock 16k+8 and tx_done is checked as 0 one clock before clock 16·bits and as 1 at that clock. For the divided tick sources the tick phase is free-running, so tx_done is checked as still 0 just before the earliest possible finish and as 1 just after the latest. Mode 0 reception is checked to finish exactly 96 clocks after its start edge. Asynchronous reception finishes near the middle of the stop bit, so those flags and data are checked after the stop bit and an idle gap of two bit times, before the next frame begins.

// File: rtl/sp_pkg.sv
package sp_pkg;

    typedef enum logic [1:0] {
        SP_SHIFT     = 2'd0,
        SP_UART8     = 2'd1,
        SP_UART9_FIX = 2'd2,
        SP_UART9_VAR = 2'd3
    } sp_mode_e;

    localparam int DATA_W = 8;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              bit9;
        logic              stop;
    } sp_frame_t;

    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

    function automatic logic is_nine(input sp_mode_e m);
        return (m == SP_UART9_FIX) || (m == SP_UART9_VAR);
    endfunction

endpackage

// File: rtl/sp_tick.sv
module sp_tick
    import sp_pkg::*;
#(
    parameter int FIX_FAST = 2,
    parameter int FIX_SLOW = 4
) (
    input  logic     clk,
    input  logic     rst,
    input  sp_mode_e mode,
    input  logic     dbl,
    input  logic     timer_tick,
    output logic     tick
);
    localparam int PW = $clog2(FIX_SLOW);
    localparam logic [PW-1:0] SLOW_LAST = PW'(FIX_SLOW - 1);
    localparam logic [PW-1:0] FAST_MASK = PW'(FIX_FAST - 1);

    logic [PW-1:0] pre_q;
    logic          half_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q  <= '0;
            half_q <= 1'b0;
        end else begin
            pre_q <= (pre_q == SLOW_LAST) ? '0 : pre_q + 1'b1;
            if (timer_tick) half_q <= ~half_q;
        end
    end

    always_comb begin
        if (mode == SP_UART9_FIX)
            tick = dbl ? ((pre_q & FAST_MASK) == FAST_MASK) : (pre_q == SLOW_LAST);
        else
            tick = timer_tick & (dbl | half_q);
    end

    a_r5_slow_fixed_gap: assert property (@(posedge clk) disable iff (rst)
        (mode == SP_UART9_FIX && !dbl && tick) |=> !tick)
        else $error("R5: fixed slow tick on consecutive clocks");

endmodule

// File: rtl/sp_shift0.sv
module sp_shift0
    import sp_pkg::*;
#(
    parameter int DIV = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              tx_start,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              rx_start,
    input  logic              rxd_s,
    output logic              sclk,
    output logic              dout,
    output logic              oe,
    output logic              tx_fin,
    output logic              rx_fin,
    output logic [DATA_W-1:0] rx_data
);
    localparam int PHW = $clog2(DIV);
    localparam int BW  = $clog2(DATA_W);
    localparam logic [PHW-1:0] PH_LAST = PHW'(DIV - 1);
    localparam logic [PHW-1:0] PH_HALF = PHW'(DIV / 2);
    localparam logic [PHW-1:0] PH_SAMP = PHW'(DIV / 2 - 1);
    localparam logic [BW-1:0]  B_LAST  = BW'(DATA_W - 1);

    logic              busy_q, is_tx_q;
    logic [PHW-1:0]    ph_q;
    logic [BW-1:0]     bidx_q;
    logic [DATA_W-1:0] sh_q;
    logic              fin_now;

    assign fin_now = busy_q && (ph_q == PH_LAST) && (bidx_q == B_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q  <= 1'b0;
            is_tx_q <= 1'b0;
            ph_q    <= '0;
            bidx_q  <= '0;
            sh_q    <= '0;
        end else if (!en) begin
            busy_q <= 1'b0;
        end else if (!busy_q) begin
            ph_q   <= '0;
            bidx_q <= '0;
            if (tx_start) begin
                busy_q  <= 1'b1;
                is_tx_q <= 1'b1;
                sh_q    <= tx_data;
            end else if (rx_start) begin
                busy_q  <= 1'b1;
                is_tx_q <= 1'b0;
            end
        end else begin
            if (ph_q == PH_LAST) begin
                ph_q   <= '0;
                bidx_q <= bidx_q + 1'b1;
                if (is_tx_q) sh_q <= {1'b0, sh_q[DATA_W-1:1]};
                if (bidx_q == B_LAST) busy_q <= 1'b0;
            end else begin
                ph_q <= ph_q + 1'b1;
            end
            if (!is_tx_q && ph_q == PH_SAMP) sh_q <= {rxd_s, sh_q[DATA_W-1:1]};
        end
    end

    assign sclk    = busy_q ? (ph_q >= PH_HALF) : 1'b1;
    assign dout    = sh_q[0];
    assign oe      = busy_q & is_tx_q;
    assign tx_fin  = fin_now & is_tx_q;
    assign rx_fin  = fin_now & ~is_tx_q;
    assign rx_data = sh_q;

    a_r2_clock_rises_mid_bit: assert property (@(posedge clk) disable iff (rst)
        (busy_q && ph_q == PH_SAMP && en) |=> sclk)
        else $error("R2: shift clock not high in second half of bit");

endmodule

// File: rtl/sp_uart_tx.sv
module sp_uart_tx
    import sp_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              tick,
    input  logic              start,
    input  logic              nine,
    input  logic [DATA_W-1:0] data,
    input  logic              bit9,
    output logic              txd,
    output logic              fin
);
    localparam int FW = DATA_W + 3;
    localparam int CW = $clog2(OVS);
    localparam int LW = $clog2(FW + 1);
    localparam logic [CW-1:0] C_LAST = CW'(OVS - 1);
    localparam logic [LW-1:0] L_NINE = LW'(FW);
    localparam logic [LW-1:0] L_EIGHT = LW'(FW - 1);
    localparam logic [LW-1:0] L_ONE = LW'(1);

    logic          busy_q;
    logic [FW-1:0] sh_q;
    logic [CW-1:0] cnt_q;
    logic [LW-1:0] left_q;

    assign fin = busy_q && tick && (cnt_q == C_LAST) && (left_q == L_ONE);
    assign txd = busy_q ? sh_q[0] : 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            sh_q   <= '1;
            cnt_q  <= '0;
            left_q <= '0;
        end else if (!en) begin
            busy_q <= 1'b0;
        end else if (!busy_q) begin
            if (start) begin
                busy_q <= 1'b1;
                cnt_q  <= '0;
                sh_q   <= {1'b1, (nine ? bit9 : 1'b1), data, 1'b0};
                left_q <= nine ? L_NINE : L_EIGHT;
            end
        end else if (tick) begin
            if (cnt_q == C_LAST) begin
                cnt_q  <= '0;
                sh_q   <= {1'b1, sh_q[FW-1:1]};
                left_q <= left_q - 1'b1;
                if (left_q == L_ONE) busy_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    a_r4_start_bit_low: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_q) |-> !txd)
        else $error("R4: frame did not open with a low start bit");

    a_r4_stop_bit_high: assert property (@(posedge clk) disable iff (rst)
        fin |-> txd)
        else $error("R4: last bit of frame not high");

endmodule

// File: rtl/sp_uart_rx.sv
module sp_uart_rx
    import sp_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      en,
    input  logic      tick,
    input  logic      nine,
    input  logic      rxd_s,
    output logic      fin,
    output sp_frame_t frame
);
    localparam int CW = $clog2(OVS);
    localparam int IW = $clog2(DATA_W + 3);
    localparam logic [CW-1:0] C_LAST = CW'(OVS - 1);
    localparam logic [CW-1:0] C_S1   = CW'(OVS / 2 - 1);
    localparam logic [CW-1:0] C_S2   = CW'(OVS / 2);
    localparam logic [CW-1:0] C_S3   = CW'(OVS / 2 + 1);
    localparam logic [IW-1:0] I_DLAST = IW'(DATA_W);
    localparam logic [IW-1:0] I_NINTH = IW'(DATA_W + 1);

    logic              act_q, v1_q, v2_q, b9_q;
    logic [CW-1:0]     cnt_q;
    logic [IW-1:0]     idx_q;
    logic [DATA_W-1:0] dsh_q;
    logic              vote, decide;
    logic [IW-1:0]     last_idx;

    assign vote     = maj3(v1_q, v2_q, rxd_s);
    assign last_idx = nine ? IW'(DATA_W + 2) : IW'(DATA_W + 1);
    assign decide   = act_q && tick && (cnt_q == C_S3);
    assign fin      = decide && (idx_q == last_idx);

    assign frame.data = dsh_q;
    assign frame.bit9 = b9_q;
    assign frame.stop = vote;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= 1'b0;
            cnt_q <= '0;
            idx_q <= '0;
            v1_q  <= 1'b1;
            v2_q  <= 1'b1;
            b9_q  <= 1'b0;
            dsh_q <= '0;
        end else if (!en) begin
            act_q <= 1'b0;
        end else if (!act_q) begin
            if (tick && !rxd_s) begin
                act_q <= 1'b1;
                cnt_q <= CW'(1);
                idx_q <= '0;
            end
        end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == C_LAST) idx_q <= idx_q + 1'b1;
            if (cnt_q == C_S1) v1_q <= rxd_s;
            if (cnt_q == C_S2) v2_q <= rxd_s;
            if (cnt_q == C_S3) begin
                if (idx_q == '0) begin
                    if (vote) act_q <= 1'b0;
                end else if (idx_q <= I_DLAST) begin
                    dsh_q <= {vote, dsh_q[DATA_W-1:1]};
                end else if (idx_q == I_NINTH && nine) begin
                    b9_q <= vote;
                end
                if (idx_q == last_idx) act_q <= 1'b0;
            end
        end
    end

    a_r10_idle_when_disabled: assert property (@(posedge clk) disable iff (rst)
        !en |=> !act_q)
        else $error("R10: receiver active while disabled");

    a_r6_false_start_drops: assert property (@(posedge clk) disable iff (rst)
        (decide && idx_q == '0 && vote && en) |=> !act_q)
        else $error("R6: false start not rejected");

endmodule

// File: rtl/serial_port_ctl.sv
module serial_port_ctl
    import sp_pkg::*;
#(
    parameter int SHIFT_DIV    = 12,
    parameter int OVERSAMPLE   = 16,
    parameter int FIX_FAST_DIV = 2,
    parameter int FIX_SLOW_DIV = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        mode,
    input  logic              rx_enable,
    input  logic              addr_filter,
    input  logic              clk_double,
    input  logic              tx_bit9,
    input  logic              timer_tick,
    input  logic              tx_load,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              clr_tx_done,
    input  logic              clr_rx_done,
    input  logic              clr_err,
    input  logic              rxd_in,
    output logic              rxd_out,
    output logic              rxd_oe,
    output logic              txd_out,
    output logic              tx_done,
    output logic              rx_done,
    output logic              rx_error,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_bit9
);
    localparam int SYNC_N = 2;

    sp_mode_e          m;
    logic              shift_mode, nine;
    logic [SYNC_N-1:0] sync_q;
    logic              rxd_s;

    assign m          = sp_mode_e'(mode);
    assign shift_mode = (m == SP_SHIFT);
    assign nine       = is_nine(m);

    always_ff @(posedge clk) begin
        if (rst) sync_q <= '1;
        else     sync_q <= {sync_q[SYNC_N-2:0], rxd_in};
    end
    assign rxd_s = sync_q[SYNC_N-1];

    // synchronous mode engine
    logic              s0_sclk, s0_tx_fin, s0_rx_fin;
    logic [DATA_W-1:0] s0_data;

    sp_shift0 #(.DIV(SHIFT_DIV)) u_shift0 (
        .clk     (clk),
        .rst     (rst),
        .en      (shift_mode),
        .tx_start(tx_load),
        .tx_data (tx_data),
        .rx_start(rx_enable & ~rx_done & ~tx_load),
        .rxd_s   (rxd_s),
        .sclk    (s0_sclk),
        .dout    (rxd_out),
        .oe      (rxd_oe),
        .tx_fin  (s0_tx_fin),
        .rx_fin  (s0_rx_fin),
        .rx_data (s0_data)
    );

    // frame modes
    logic      tick, utx_txd, utx_fin, urx_fin;
    sp_frame_t frm;

    sp_tick #(.FIX_FAST(FIX_FAST_DIV), .FIX_SLOW(FIX_SLOW_DIV)) u_tick (
        .clk       (clk),
        .rst       (rst),
        .mode      (m),
        .dbl       (clk_double),
        .timer_tick(timer_tick),
        .tick      (tick)
    );

    sp_uart_tx #(.OVS(OVERSAMPLE)) u_tx (
        .clk  (clk),
        .rst  (rst),
        .en   (~shift_mode),
        .tick (tick),
        .start(tx_load),
        .nine (nine),
        .data (tx_data),
        .bit9 (tx_bit9),
        .txd  (utx_txd),
        .fin  (utx_fin)
    );

    sp_uart_rx #(.OVS(OVERSAMPLE)) u_rx (
        .clk  (clk),
        .rst  (rst),
        .en   (~shift_mode & rx_enable),
        .tick (tick),
        .nine (nine),
        .rxd_s(rxd_s),
        .fin  (urx_fin),
        .frame(frm)
    );

    assign txd_out = shift_mode ? s0_sclk : utx_txd;

    // acceptance, overrun and framing
    logic pass, uart_take, load_rx, overrun, framing;

    assign pass      = nine ? (~addr_filter | frm.bit9) : (~addr_filter | frm.stop);
    assign uart_take = urx_fin & pass;
    assign load_rx   = (uart_take | s0_rx_fin) & ~rx_done;
    assign overrun   = uart_take & rx_done;
    assign framing   = urx_fin & ~frm.stop;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_done  <= 1'b0;
            rx_done  <= 1'b0;
            rx_error <= 1'b0;
            rx_data  <= '0;
            rx_bit9  <= 1'b0;
        end else begin
            tx_done  <= s0_tx_fin | utx_fin | (tx_done & ~clr_tx_done);
            rx_done  <= load_rx | (rx_done & ~clr_rx_done);
            rx_error <= overrun | framing | (rx_error & ~clr_err);
            if (load_rx) begin
                rx_data <= s0_rx_fin ? s0_data : frm.data;
                if (!s0_rx_fin) rx_bit9 <= nine ? frm.bit9 : frm.stop;
            end
        end
    end

    a_r1_flags_clear_after_reset: assert property (@(posedge clk)
        rst |=> (!tx_done && !rx_done && !rx_error))
        else $error("R1: flags not clear after reset");

    a_r12_error_sticky: assert property (@(posedge clk) disable iff (rst)
        (rx_error && !clr_err) |=> rx_error)
        else $error("R12: error flag dropped without clear");

    a_r11_buffer_held: assert property (@(posedge clk) disable iff (rst)
        (rx_done && !clr_rx_done) |=> $stable(rx_data))
        else $error("R11: buffer changed while receive-done set");

    a_r9_filter_blocks_flag: assert property (@(posedge clk) disable iff (rst)
        (urx_fin && nine && addr_filter && !frm.bit9 && !clr_rx_done)
        |=> (rx_done == $past(rx_done)))
        else $error("R9: filtered frame changed receive-done");

    a_r2_pin_released_outside_mode0: assert property (@(posedge clk) disable iff (rst)
        !shift_mode |=> !rxd_oe)
        else $error("R2: receive pin driven outside mode 0");

endmodule

// File: tb/serial_port_ctl_tb_top.sv
`timescale 1ns/1ps
module serial_port_ctl_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] mode = 2'd1;
    logic       rx_enable = 1'b0, addr_filter = 1'b0, clk_double = 1'b1, tx_bit9 = 1'b0;
    logic       timer_tick = 1'b1, tx_load = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       clr_tx_done = 1'b0, clr_rx_done = 1'b0, clr_err = 1'b0;
    logic       rxd_drv = 1'b1;
    logic       rxd_out, rxd_oe, txd_out, tx_done, rx_done, rx_error, rx_bit9;
    logic [7:0] rx_data;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    serial_port_ctl dut_i (
        .clk(clk), .rst(rst), .mode(mode), .rx_enable(rx_enable),
        .addr_filter(addr_filter), .clk_double(clk_double), .tx_bit9(tx_bit9),
        .timer_tick(timer_tick), .tx_load(tx_load), .tx_data(tx_data),
        .clr_tx_done(clr_tx_done), .clr_rx_done(clr_rx_done), .clr_err(clr_err),
        .rxd_in(rxd_drv), .rxd_out(rxd_out), .rxd_oe(rxd_oe), .txd_out(txd_out),
        .tx_done(tx_done), .rx_done(rx_done), .rx_error(rx_error),
        .rx_data(rx_data), .rx_bit9(rx_bit9)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic clear_all();
        @(negedge clk);
        clr_tx_done = 1'b1; clr_rx_done = 1'b1; clr_err = 1'b1;
        @(negedge clk);
        clr_tx_done = 1'b0; clr_rx_done = 1'b0; clr_err = 1'b0;
    endtask

    task automatic load(input logic [7:0] d);
        @(negedge clk);
        tx_data = d; tx_load = 1'b1;
        @(negedge clk);
        tx_load = 1'b0;
    endtask

    function automatic logic [10:0] mkframe(input logic [7:0] d, input logic b9,
                                            input logic stp, input bit nine);
        return nine ? {stp, b9, d, 1'b0} : {1'b0, stp, d, 1'b0};
    endfunction

    task automatic send(input logic [10:0] bits, input int nb, input int per);
        for (int k = 0; k < nb; k++) begin
            rxd_drv = bits[k];
            repeat (per) @(negedge clk);
        end
        rxd_drv = 1'b1;
        repeat (2 * per) @(negedge clk);
    endtask

    // frame transmit with one tick per clock: bit k held in clocks 16k..16k+15
    task automatic tx_frame(input string tag, input logic [7:0] d, input logic b9, input bit nine);
        logic [10:0] f;
        int nb;
        f  = mkframe(d, b9, 1'b1, nine);
        nb = nine ? 11 : 10;
        load(d);
        for (int j = 0; j <= nb * 16; j++) begin
            if (j > 0) @(negedge clk);
            if (j % 16 == 8) chk({tag, " bit"}, txd_out, f[j / 16]);
            if (j == nb * 16 - 1) chk({tag, " done early"}, tx_done, 0);
            if (j == nb * 16) chk({tag, " done"}, tx_done, 1);
        end
        clear_all();
    endtask

    task automatic tx_window(input string tag, input int lo, input int hi);
        load(8'h5B);
        repeat (lo) @(negedge clk);
        chk({tag, " not yet done"}, tx_done, 0);
        repeat (hi - lo) @(negedge clk);
        chk({tag, " done"}, tx_done, 1);
        clear_all();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int errs;
        int first;
        int bi;
        logic prev;
        logic [7:0] pat;

        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 txd idle", txd_out, 1);
        chk("R1 oe", rxd_oe, 0);
        chk("R1 flags", {tx_done, rx_done, rx_error}, 0);

        // R2 mode 0 transmit
        mode = 2'd0;
        load(8'hA5);
        errs = 0;
        for (int j = 0; j <= 96; j++) begin
            if (j > 0) @(negedge clk);
            if (j < 96) begin
                if (txd_out != ((j % 12) >= 6)) errs++;
                if (!rxd_oe) errs++;
                if (j % 12 == 3) chk("R2 data bit", rxd_out, pat_bit(8'hA5, j / 12));
            end
            if (j == 95) chk("R2 done early", tx_done, 0);
            if (j == 96) begin
                chk("R2 done", tx_done, 1);
                chk("R2 pin released", rxd_oe, 0);
            end
        end
        chk("R2 shift clock shape", errs, 0);
        clear_all();

        // R3 mode 0 receive
        pat = 8'h3C;
        prev = 1'b1; bi = 0; first = -1;
        @(negedge clk);
        rx_enable = 1'b1;
        for (int j = 0; j < 110; j++) begin
            @(negedge clk);
            if (!txd_out && prev && bi < 8) begin
                rxd_drv = pat[bi];
                bi++;
            end
            prev = txd_out;
            if (rx_done && first < 0) first = j;
        end
        rx_enable = 1'b0;
        rxd_drv = 1'b1;
        chk("R3 done cycle", first, 96);
        chk("R3 data", rx_data, 8'h3C);
        clear_all();

        // R4 frame transmit, one tick per clock
        mode = 2'd1; clk_double = 1'b1;
        repeat (4) @(negedge clk);
        tx_frame("R4 mode1", 8'h96, 1'b0, 1'b0);
        mode = 2'd3;
        tx_frame("R4 mode3", 8'h4D, 1'b0, 1'b1);
        tx_bit9 = 1'b1;
        tx_frame("R4 mode3 b9", 8'hF0, 1'b1, 1'b1);
        tx_bit9 = 1'b0;

        // R5 tick sources
        mode = 2'd1; clk_double = 1'b0;
        tx_window("R5 mode1 halved", 317, 321);
        mode = 2'd2; clk_double = 1'b1;
        tx_window("R5 mode2 fast", 349, 353);
        clk_double = 1'b0;
        tx_window("R5 mode2 slow", 699, 705);

        // R10 disabled receiver
        mode = 2'd1; clk_double = 1'b1; rx_enable = 1'b0;
        send(mkframe(8'h77, 1'b0, 1'b1, 1'b0), 10, 16);
        chk("R10 no done", rx_done, 0);
        chk("R10 data kept", rx_data, 8'h3C);

        // R7 mode 1, filter off
        rx_enable = 1'b1;
        send(mkframe(8'h5A, 1'b0, 1'b1, 1'b0), 10, 16);
        chk("R7 done", rx_done, 1);
        chk("R7 data", rx_data, 8'h5A);
        chk("R7 stop to bit9", rx_bit9, 1);
        chk("R7 no error", rx_error, 0);
        clear_all();

        // R12 framing fault, mode 1 filter off still accepts
        send(mkframe(8'hC3, 1'b0, 1'b0, 1'b0), 10, 16);
        chk("R12 accepted", rx_done, 1);
        chk("R12 data", rx_data, 8'hC3);
        chk("R7 bad stop to bit9", rx_bit9, 0);
        clr_rx_done = 1'b1;
        @(negedge clk);
        clr_rx_done = 1'b0;
        repeat (20) @(negedge clk);
        chk("R12 error sticky", rx_error, 1);
        clear_all();
        chk("R12 error cleared", rx_error, 0);

        // R8 mode 1, filter on
        addr_filter = 1'b1;
        send(mkframe(8'h11, 1'b0, 1'b0, 1'b0), 10, 16);
        chk("R8 rejected done", rx_done, 0);
        chk("R8 rejected data", rx_data, 8'hC3);
        send(mkframe(8'h22, 1'b0, 1'b1, 1'b0), 10, 16);
        chk("R8 accepted", rx_done, 1);
        chk("R8 data", rx_data, 8'h22);
        addr_filter = 1'b0;
        clear_all();

        // R6 false start rejection
        rxd_drv = 1'b0;
        repeat (5) @(negedge clk);
        rxd_drv = 1'b1;
        repeat (300) @(negedge clk);
        chk("R6 false start ignored", rx_done, 0);
        send(mkframe(8'h81, 1'b0, 1'b1, 1'b0), 10, 16);
        chk("R6 next frame", rx_data, 8'h81);
        clear_all();

        // R11 overrun
        send(mkframe(8'h44, 1'b0, 1'b1, 1'b0), 10, 16);
        chk("R11 first ok", rx_error, 0);
        send(mkframe(8'h99, 1'b0, 1'b1, 1'b0), 10, 16);
        chk("R11 error", rx_error, 1);
        chk("R11 data kept", rx_data, 8'h44);
        chk("R11 done held", rx_done, 1);
        clear_all();

        // R9 nine-bit reception and filter
        mode = 2'd3;
        repeat (4) @(negedge clk);
        send(mkframe(8'h37, 1'b0, 1'b1, 1'b1), 11, 16);
        chk("R9 accepted", rx_done, 1);
        chk("R9 data", rx_data, 8'h37);
        chk("R9 bit9 zero", rx_bit9, 0);
        clear_all();
        addr_filter = 1'b1;
        send(mkframe(8'h48, 1'b0, 1'b1, 1'b1), 11, 16);
        chk("R9 filtered done", rx_done, 0);
        chk("R9 filtered data", rx_data, 8'h37);
        send(mkframe(8'h6E, 1'b1, 1'b1, 1'b1), 11, 16);
        chk("R9 address frame", rx_done, 1);
        chk("R9 address data", rx_data, 8'h6E);
        chk("R9 bit9 one", rx_bit9, 1);
        addr_filter = 1'b0;
        clear_all();

        // R5 mode 2 reception at fixed rate
        mode = 2'd2; clk_double = 1'b1;
        repeat (4) @(negedge clk);
        send(mkframe(8'hE7, 1'b1, 1'b1, 1'b1), 11, 32);
        chk("R5 mode2 rx done", rx_done, 1);
        chk("R5 mode2 rx data", rx_data, 8'hE7);
        clear_all();

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    function automatic int pat_bit(input logic [7:0] d, input int k);
        return int'(d[k]);
    endfunction

endmodule